// File: doc/BRIEF.md
# Register-Commanded Single-Byte I2C Write Master

This block is a small, dedicated I2C master that puts one register write on the bus for each command. A processor loads one command word that holds a 7-bit target address, an 8-bit register address and an 8-bit data byte. Setting the start flag in the same word sends START, the address byte with the write direction, the register address, the data byte and STOP. The start flag reads back as 1 while the frame is on the bus. Hardware clears it when the STOP has been sent, so software polls that one bit to learn that the write is done.

The SCL high and low times come from a clock setting register. Each field holds a cycle count that is stored below the true duration by a fixed amount: 5 reference cycles for high and 7 for low. Both bus lines are open-drain: an output-enable pulls the line low, and deasserting it releases the line. A target that fails to acknowledge any byte stops the frame and sets a sticky error flag. A mode register holds a fast-signalling enable and a 2-bit master code. Software can read and write it, but it has no effect on the bus.

Top module: `i2c_bypass_writer`

## Requirements
- R1: Register offset 0 (command word) holds the target address in bits 6:0, the register address in bits 15:8, the data byte in bits 23:16 and the busy/start flag in bit 24. Bit 7 and bits 31:25 read as 0.
- R2: A write to offset 0 with bit 24 set while idle starts a frame, and bit 24 reads 1 on the next cycle. It reads 0 once STOP has been sent. A write with bit 24 clear stores the fields and causes no bus activity. While idle, both lines are released.
- R3: The frame is START, then {target, 0}, register address and data, each byte MSB first and followed by an acknowledge slot in which SDA is released, then STOP.
- R4: Offset 1 bits 7:0 set the SCL high time to that value plus 5 cycles. This applies to every data-bit high phase and to the START hold (SDA low to first SCL low).
- R5: Offset 1 bits 15:8 set the SCL low time to that value plus 7 cycles. This applies to every SCL low phase.
- R6: Inside a frame, SDA changes only while SCL is held low. The only exceptions are the START and STOP edges, so each frame has exactly one START and one STOP.
- R7: If the acknowledge slot of any byte reads high, no later byte is sent. STOP follows, bit 24 clears, and the error flag sets and stays set until reset.
- R8: Writes to offset 0 while bit 24 is 1 are ignored: the stored fields do not change and the frame on the bus is unchanged.
- R9: Offset 2 stores a fast-signalling enable in bit 3 and a master code in bits 1:0. The other bits read 0. The values have no effect on the bus sequence or its timing.
- R10: Reset releases both lines and clears bit 24 and the error flag. Offset 1 then reads the default high count 10 and low count 14.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 command, 1 clock setting, 2 mode |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA line level |
| nack_err | output | 1 | Sticky not-acknowledged flag |

## Verification
The bench models an open-drain target that decodes every byte, acknowledges a chosen number of them and measures each SCL phase. A wrong offset or swapped count field would show up as a low or high run off by a fixed number of cycles. The smallest counts (7-cycle low) and the largest counts (255) are exercised, because a midpoint or wrap error in the phase counter shows only there. A NACK on the first, middle and last byte is applied: a design that keeps sending after a NACK decodes extra bytes, and one that forgets the error flag reads it back as 0 after a later clean frame. A second command written during a busy frame must not alter the decoded bytes or the read-back fields.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

    localparam int WORD_W     = 32;
    localparam int START_BIT  = 24;
    localparam int FRAME_LEN  = 3;

    typedef enum logic [1:0] {
        SEL_CMD  = 2'd0,
        SEL_CLK  = 2'd1,
        SEL_MODE = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [7:0] data;
        logic [7:0] reg_addr;
        logic [6:0] target;
    } bypass_cmd_t;

    typedef struct packed {
        logic [7:0] lo;
        logic [7:0] hi;
    } clk_cfg_t;

    typedef struct packed {
        logic       fast_en;
        logic [1:0] mcode;
    } mode_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_LOW,
        ST_HIGH,
        ST_STOP_LOW,
        ST_STOP_HIGH
    } bus_state_e;

    function automatic logic [WORD_W-1:0] pack_cmd(bypass_cmd_t c, logic busy);
        return {7'd0, busy, c.data, c.reg_addr, 1'b0, c.target};
    endfunction

    function automatic bypass_cmd_t unpack_cmd(logic [WORD_W-1:0] w);
        bypass_cmd_t c;
        c.target   = w[6:0];
        c.reg_addr = w[15:8];
        c.data     = w[23:16];
        return c;
    endfunction

    function automatic logic [7:0] frame_byte(bypass_cmd_t c, logic [1:0] idx);
        case (idx)
            2'd0:    return {c.target, 1'b0};
            2'd1:    return c.reg_addr;
            default: return c.data;
        endcase
    endfunction

endpackage

// File: rtl/i2cb_regs.sv
module i2cb_regs
    import i2cb_pkg::*;
#(
    parameter logic [7:0] DEF_HI = 8'd10,
    parameter logic [7:0] DEF_LO = 8'd14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic              xfer_done,
    input  logic              xfer_nack,
    output logic              launch,
    output logic              busy,
    output logic              err,
    output bypass_cmd_t       cmd,
    output clk_cfg_t          ccfg,
    output mode_cfg_t         mcfg,
    output logic [WORD_W-1:0] rdata
);

    reg_sel_e sel;
    logic     cmd_wr;

    assign sel    = reg_sel_e'(reg_sel);
    assign cmd_wr = reg_we && (sel == SEL_CMD) && !busy;
    assign launch = cmd_wr && reg_wdata[START_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd  <= '0;
            busy <= 1'b0;
            err  <= 1'b0;
            ccfg <= '{lo: DEF_LO, hi: DEF_HI};
            mcfg <= '0;
        end else begin
            if (cmd_wr) begin
                cmd <= unpack_cmd(reg_wdata);
            end
            if (launch) begin
                busy <= 1'b1;
            end else if (xfer_done) begin
                busy <= 1'b0;
            end
            if (xfer_done && xfer_nack) begin
                err <= 1'b1;
            end
            if (reg_we && sel == SEL_CLK) begin
                ccfg <= '{lo: reg_wdata[15:8], hi: reg_wdata[7:0]};
            end
            if (reg_we && sel == SEL_MODE) begin
                mcfg <= '{fast_en: reg_wdata[3], mcode: reg_wdata[1:0]};
            end
        end
    end

    always_comb begin
        case (sel)
            SEL_CMD:  rdata = pack_cmd(cmd, busy);
            SEL_CLK:  rdata = {16'd0, ccfg.lo, ccfg.hi};
            SEL_MODE: rdata = {28'd0, mcfg.fast_en, 1'b0, mcfg.mcode};
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/i2cb_phase_timer.sv
module i2cb_phase_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [CNT_W-1:0] len,
    output logic             last,
    output logic             mid
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt == len - 1'b1);
    assign mid  = (cnt == (len >> 1));

endmodule

// File: rtl/i2cb_seq.sv
module i2cb_seq
    import i2cb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        launch,
    input  bypass_cmd_t cmd,
    input  logic        last,
    input  logic        mid,
    input  logic        sda_in,
    output bus_state_e  state,
    output logic        scl_oe,
    output logic        sda_oe,
    output logic        done,
    output logic        nack
);

    localparam logic [3:0] ACK_SLOT  = 4'd8;
    localparam logic [1:0] LAST_BYTE = 2'(FRAME_LEN - 1);

    logic [3:0] bit_idx;
    logic [1:0] byte_idx;
    logic       sda_drv;
    logic [7:0] cur_byte;
    logic       cur_bit;

    always_comb begin
        cur_byte = frame_byte(cmd, byte_idx);
        cur_bit  = (bit_idx < ACK_SLOT) ? cur_byte[3'd7 - bit_idx[2:0]] : 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            bit_idx  <= '0;
            byte_idx <= '0;
            sda_drv  <= 1'b0;
            nack     <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (launch) begin
                        state    <= ST_START;
                        sda_drv  <= 1'b1;
                        bit_idx  <= '0;
                        byte_idx <= '0;
                        nack     <= 1'b0;
                    end
                end
                ST_START: begin
                    if (last) state <= ST_LOW;
                end
                ST_LOW: begin
                    if (mid)  sda_drv <= ~cur_bit;
                    if (last) state   <= ST_HIGH;
                end
                ST_HIGH: begin
                    if (last) begin
                        if (bit_idx == ACK_SLOT) begin
                            nack <= sda_in;
                            if (sda_in || byte_idx == LAST_BYTE) begin
                                state <= ST_STOP_LOW;
                            end else begin
                                state    <= ST_LOW;
                                bit_idx  <= '0;
                                byte_idx <= byte_idx + 1'b1;
                            end
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                            state   <= ST_LOW;
                        end
                    end
                end
                ST_STOP_LOW: begin
                    if (mid)  sda_drv <= 1'b1;
                    if (last) state   <= ST_STOP_HIGH;
                end
                ST_STOP_HIGH: begin
                    if (last) begin
                        sda_drv <= 1'b0;
                        state   <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign scl_oe = (state == ST_LOW) || (state == ST_STOP_LOW);
    assign sda_oe = sda_drv;
    assign done   = (state == ST_STOP_HIGH) && last;

endmodule

// File: rtl/i2c_bypass_writer.sv
module i2c_bypass_writer
    import i2cb_pkg::*;
#(
    parameter logic [7:0] DEF_HI = 8'd10,
    parameter logic [7:0] DEF_LO = 8'd14,
    parameter int         HI_OFS = 5,
    parameter int         LO_OFS = 7
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        scl_oe,
    output logic        sda_oe,
    input  logic        sda_in,
    output logic        nack_err
);

    localparam int MAX_OFS = (HI_OFS > LO_OFS) ? HI_OFS : LO_OFS;
    localparam int CNT_W   = $clog2(256 + MAX_OFS + 1);

    bypass_cmd_t      cmd_q;
    clk_cfg_t         ccfg;
    mode_cfg_t        mcfg;
    bus_state_e       state;
    logic             launch;
    logic             busy_q;
    logic             done;
    logic             nack;
    logic             last;
    logic             mid;
    logic             in_low;
    logic [CNT_W-1:0] phase_len;

    i2cb_regs #(
        .DEF_HI (DEF_HI),
        .DEF_LO (DEF_LO)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .xfer_done (done),
        .xfer_nack (nack),
        .launch    (launch),
        .busy      (busy_q),
        .err       (nack_err),
        .cmd       (cmd_q),
        .ccfg      (ccfg),
        .mcfg      (mcfg),
        .rdata     (reg_rdata)
    );

    assign in_low    = (state == ST_LOW) || (state == ST_STOP_LOW);
    assign phase_len = in_low ? (CNT_W'(ccfg.lo) + CNT_W'(LO_OFS))
                              : (CNT_W'(ccfg.hi) + CNT_W'(HI_OFS));

    i2cb_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (launch || (last && state != ST_IDLE)),
        .len     (phase_len),
        .last    (last),
        .mid     (mid)
    );

    i2cb_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .launch (launch),
        .cmd    (cmd_q),
        .last   (last),
        .mid    (mid),
        .sda_in (sda_in),
        .state  (state),
        .scl_oe (scl_oe),
        .sda_oe (sda_oe),
        .done   (done),
        .nack   (nack)
    );

endmodule

// File: rtl/i2cb_checker.sv
module i2cb_checker (
    input logic        clk,
    input logic        rst,
    input logic        reg_we,
    input logic [1:0]  reg_sel,
    input logic [31:0] reg_wdata,
    input logic        scl_oe,
    input logic        sda_oe,
    input logic        busy,
    input logic        nack_err,
    input logic [22:0] cmd_bits
);

    AST_SDA_STEADY_HIGH: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe)); // R6

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!scl_oe && !sda_oe)); // R2

    AST_LAUNCH_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (!busy && reg_we && reg_sel == 2'd0 && reg_wdata[24]) |=> busy); // R2

    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && reg_we && reg_sel == 2'd0) |=> $stable(cmd_bits)); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        nack_err |=> nack_err); // R7

    AST_END_RELEASES: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (!scl_oe && !sda_oe)); // R7

endmodule

bind i2c_bypass_writer i2cb_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .busy      (busy_q),
    .nack_err  (nack_err),
    .cmd_bits  (cmd_q)
);

// File: tb/sim_i2c_bypass_writer.sv
module sim_i2c_bypass_writer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        scl_oe, sda_oe, nack_err;
    logic        tgt_pull = 1'b0;
    logic        sda_in;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // target model state
    int   exp_hi = 15, exp_lo = 21;
    int   ack_limit = 3;
    int   run_len = 0;
    int   bitcnt = 0;
    int   nbytes = 0;
    int   starts = 0, stops = 0;
    int   hi_bad = 0, lo_bad = 0;
    bit   in_xfer = 0;
    bit   prev_scl = 1, prev_sda = 1;
    logic [7:0] shreg;
    logic [7:0] got [0:3];

    assign sda_in = !(sda_oe || tgt_pull);

    i2c_bypass_writer u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in), .nack_err(nack_err)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 190000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // open-drain target: decodes bytes, acknowledges, measures phases
    always @(negedge clk) begin
        bit scl_l, sda_l;
        scl_l = !scl_oe;
        sda_l = !(sda_oe || tgt_pull);
        if (scl_l == prev_scl) begin
            run_len++;
        end else begin
            if (!prev_scl && scl_l) begin
                if (in_xfer) begin
                    if (run_len != exp_lo) lo_bad++;
                    if (bitcnt < 8) shreg = {shreg[6:0], sda_l};
                    bitcnt++;
                    if (bitcnt == 9) begin
                        if (nbytes < 4) got[nbytes] = shreg;
                        nbytes++;
                        bitcnt = 0;
                    end
                end
            end else begin
                if (in_xfer) begin
                    if (run_len != exp_hi) hi_bad++;
                    tgt_pull = (bitcnt == 8) && (nbytes < ack_limit);
                end
            end
            run_len = 1;
        end
        if (scl_l && prev_scl && prev_sda && !sda_l) begin
            starts++;
            in_xfer = 1;
            bitcnt = 0;
            run_len = 1;
        end
        if (scl_l && prev_scl && !prev_sda && sda_l) begin
            stops++;
            in_xfer = 0;
            bitcnt = 0;
        end
        prev_scl = scl_l;
        prev_sda = sda_l;
    end

    function automatic logic [7:0] exp_byte(logic [6:0] sa, logic [7:0] ra, logic [7:0] d, int i);
        return (i == 0) ? {sa, 1'b0} : (i == 1) ? ra : d;
    endfunction

    function automatic logic [31:0] exp_cmd_read(logic [31:0] w, bit busy);
        return {7'd0, busy, w[23:16], w[15:8], 1'b0, w[6:0]};
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] sel, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] sel, output logic [31:0] d);
        reg_sel = sel;
        #1;
        d = reg_rdata;
    endtask

    task automatic clear_mon();
        nbytes = 0; starts = 0; stops = 0; hi_bad = 0; lo_bad = 0;
    endtask

    task automatic wait_idle(output int waited);
        logic [31:0] r;
        waited = 0;
        forever begin
            @(negedge clk);
            rd(2'd0, r);
            if (!r[24] || waited > 60000) break;
            waited++;
        end
    endtask

    // full frame with given timing and acknowledge count
    task automatic frame(logic [6:0] sa, logic [7:0] ra, logic [7:0] d,
                         int hi, int lo, int acks, bit err_exp, string tag);
        logic [31:0] r;
        int w;
        int nb_exp;
        wr(2'd1, {16'd0, 8'(lo), 8'(hi)});
        exp_hi = hi + 5;
        exp_lo = lo + 7;
        ack_limit = acks;
        clear_mon();
        wr(2'd0, {7'd0, 1'b1, d, ra, 1'b0, sa});
        rd(2'd0, r);
        check(r[24] == 1'b1, {tag, " R2 busy"}, r[24], 1);
        wait_idle(w);
        check(w <= 60000, {tag, " R2 completes"}, w, 60000);
        repeat (3) @(negedge clk);
        nb_exp = (acks >= 3) ? 3 : acks + 1;
        check(nbytes == nb_exp, {tag, " R3/R7 byte count"}, nbytes, nb_exp);
        for (int i = 0; i < nb_exp && i < nbytes; i++)
            check(got[i] == exp_byte(sa, ra, d, i), {tag, " R3 byte"}, got[i], exp_byte(sa, ra, d, i));
        check(hi_bad == 0, {tag, " R4 high time"}, hi_bad, 0);
        check(lo_bad == 0, {tag, " R5 low time"}, lo_bad, 0);
        check(starts == 1 && stops == 1, {tag, " R6 one START/STOP"}, {starts[15:0], stops[15:0]}, 32'h0001_0001);
        check(nack_err == err_exp, {tag, " R7 error flag"}, nack_err, err_exp);
        check(!scl_oe && !sda_oe, {tag, " R2 lines released"}, {scl_oe, sda_oe}, 0);
    endtask

    initial begin
        logic [31:0] r;
        int w;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        rd(2'd1, r);
        check(r == 32'h0000_0E0A, "R10 default clock setting", r, 32'h0000_0E0A);
        rd(2'd0, r);
        check(r == 32'd0, "R10 command cleared", r, 0);
        check(!scl_oe && !sda_oe && !nack_err, "R10 lines and error", {scl_oe, sda_oe, nack_err}, 0);

        // R1 field layout, R2 store without start
        clear_mon();
        wr(2'd0, 32'hFEFF_FFFF & ~32'h0100_0000);
        rd(2'd0, r);
        check(r == 32'h00FF_FF7F, "R1 field readback", r, 32'h00FF_FF7F);
        repeat (40) @(negedge clk);
        check(starts == 0 && !scl_oe && !sda_oe, "R2 no activity without start", starts, 0);

        // basic frame with defaults
        frame(7'h12, 8'h34, 8'hA5, 10, 14, 3, 0, "base");
        rd(2'd0, r);
        check(r == 32'h00A5_3412, "R1 readback after frame", r, 32'h00A5_3412);

        // R8 busy write ignored
        wr(2'd1, {16'd0, 8'd14, 8'd10});
        exp_hi = 15; exp_lo = 21; ack_limit = 3;
        clear_mon();
        wr(2'd0, 32'h0155_AA2B);
        repeat (5) @(negedge clk);
        wr(2'd0, 32'h0111_2233);
        rd(2'd0, r);
        check(r == 32'h0155_AA2B, "R8 fields unchanged while busy", r, 32'h0155_AA2B);
        wait_idle(w);
        repeat (3) @(negedge clk);
        check(nbytes == 3 && got[0] == 8'h56 && got[1] == 8'hAA && got[2] == 8'h55,
              "R8 frame unchanged", {got[0], got[1], got[2]}, 32'h0056_AA55);

        // R9 mode register has no effect
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, r);
        check(r == 32'h0000_000B, "R9 mode readback", r, 32'h0000_000B);
        frame(7'h5A, 8'h0F, 8'hF0, 3, 9, 3, 0, "R9 mode set");
        wr(2'd2, 32'd0);

        // extreme timings
        frame(7'h7F, 8'hFF, 8'h00, 0, 0, 3, 0, "min counts");
        frame(7'h01, 8'h80, 8'h01, 255, 255, 3, 0, "max counts");

        // constrained random frames
        for (int k = 0; k < 8; k++) begin
            frame(7'($urandom), 8'($urandom), 8'($urandom),
                  int'($urandom_range(0, 20)), int'($urandom_range(0, 20)), 3, 0, "random");
        end

        // R7 NACK on the middle byte, then sticky across a clean frame
        frame(7'h22, 8'h44, 8'h66, 4, 6, 1, 1, "R7 nack byte1");
        frame(7'h22, 8'h44, 8'h66, 4, 6, 3, 1, "R7 sticky");

        // R10 reset clears error
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(nack_err == 1'b0, "R10 reset clears error", nack_err, 0);

        frame(7'h33, 8'h10, 8'h20, 2, 2, 0, 1, "R7 nack address");
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        frame(7'h33, 8'h10, 8'h20, 2, 2, 2, 1, "R7 nack data");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule